// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between an interrupt source unit and one processor. It keeps a single pending slot holding a source number and its priority, together with the processor's current priority threshold and an inter-processor-interrupt (IPI) priority register. The source unit offers interrupts one at a time. The presenter keeps an offer only if it beats both the threshold and whatever is already pending. Anything it turns away or displaces goes back to the source unit as a one-cycle reject pulse that carries the source number. The level output `cpuIrq` tells the processor that a pending interrupt is waiting.

The processor works the block through a small operation port with five operations: change the threshold, set the IPI priority, accept the pending interrupt, signal end-of-interrupt, and poll without side effects. The IPI has no separate queue. It is loaded into the same pending slot under a fixed source number. When a threshold change or an end-of-interrupt leaves the slot empty, the presenter pulses a resend request so that the source unit offers again anything it had been refused.

Priorities follow the rule that lower is more favoured, and the all-ones value means "least favoured" or "none". The 32-bit status word places the threshold in bits 31:24 and the pending source number in bits 23:0. A source number of zero means the slot is empty.

Top module: `int_presenter`

## Requirements
- R1: After reset, the status word reads 0, the IPI priority reads 0xFF, `cpuIrq` is low and the pending priority is 0xFF. An accept with nothing pending therefore sets the threshold to 0xFF.
- R2: Poll (opCode 5) returns the status word in `rdData` and the IPI priority in `rdIpiPrio`, with `rdValid` high one cycle after the operation. It changes no state.
- R3: An offer whose priority is greater than or equal to the threshold is rejected: `rejValid` pulses with `rejSrc` equal to the offered source, and the slot is unchanged.
- R4: An offer is rejected when a pending interrupt exists whose priority is less than or equal to the offered priority.
- R5: Any other offer displaces the pending source, which is rejected if there is one. The offered source and priority are latched and `cpuIrq` rises one cycle after the offer.
- R6: Accept (opCode 3) returns the old status word, lowers `cpuIrq`, loads the threshold with the pending priority, clears the source field and resets the pending priority to 0xFF.
- R7: Setting the IPI priority (opCode 2, value in opData[7:0]) runs an IPI check only when the new value is below the threshold. If a pending priority is less than or equal to the new value, nothing changes. Otherwise the pending source is rejected and the slot takes source number 2 with the new value as its priority, raising `cpuIrq`.
- R8: Setting the threshold (opCode 1, value in opData[31:24]) to a value below the old one evicts the pending source when the new threshold is less than or equal to its priority. The source field clears, `cpuIrq` falls and the source is rejected.
- R9: Setting the threshold to a value equal to or above the old one while the slot is empty pulses `resendReq` and runs the IPI check against the stored IPI priority. No reject accompanies a resend.
- R10: End-of-interrupt (opCode 4) copies opData[31:24] into the threshold and pulses `eoiValid` with `eoiSrc` = opData[23:0]. If the slot is empty, it also performs the resend of R9 against the new threshold. If the slot is occupied, `resendReq` stays low.
- R11: A reject of the IPI source number 2 is dropped. `rejValid` never carries source 2.
- R12: An offer presented in the same cycle as a valid operation is discarded. It is neither latched nor rejected.
- R13: `cpuIrq` is high exactly when the source field is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| offerValid | input | 1 | Source unit offers an interrupt this cycle |
| offerSrc | input | 24 | Offered source number |
| offerPrio | input | 8 | Offered priority |
| opValid | input | 1 | Processor operation strobe |
| opCode | input | 3 | 1 threshold, 2 IPI priority, 3 accept, 4 end-of-interrupt, 5 poll |
| opData | input | 32 | Operation operand |
| rdValid | output | 1 | Read result valid (accept or poll) |
| rdData | output | 32 | Status word returned by accept or poll |
| rdIpiPrio | output | 8 | IPI priority returned by poll |
| cpuIrq | output | 1 | Level interrupt to the processor |
| rejValid | output | 1 | Reject pulse to the source unit |
| rejSrc | output | 24 | Rejected source number |
| resendReq | output | 1 | Resend request pulse to the source unit |
| eoiValid | output | 1 | End-of-interrupt pulse to the source unit |
| eoiSrc | output | 24 | Completed source number |

## Verification
Assertions check on every cycle that the level output follows the occupancy of the slot, that source 2 never appears on the reject port, that a reject and a resend never coincide, and that the slot is empty after an accept and unchanged after a poll. Assertions cannot show which of the competing rules applies to a given priority pattern. The directed scenarios cover that: ties at the threshold and at the pending priority, preemption of an IPI by a device source, eviction by a threshold drop, and the IPI reload that follows a resend.

// File: rtl/ipp_pkg.sv
package ipp_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_THRESH = 3'd1,
    OP_IPI    = 3'd2,
    OP_ACCEPT = 3'd3,
    OP_EOI    = 3'd4,
    OP_POLL   = 3'd5
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic thrFromOp;
    logic thrFromPend;
    logic pendFromOffer;
    logic pendFromIpi;
    logic pendClear;
    logic ipiWrite;
    logic rejOffer;
    logic rejCur;
    logic resend;
    logic eoiFwd;
    logic rdCap;
  } ctlStrobes_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic hasPend;
    logic offerWins;
    logic ipiWrWins;
    logic thrDown;
    logic thrEvict;
    logic ipiUnderNew;
  } dpFlags_t;

endpackage

// File: rtl/ipp_dpath.sv
module ipp_dpath
  import ipp_pkg::*;
#(
  parameter int unsigned SRC_W   = 24,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IPI_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               stb,
  input  logic [PRIO_W+SRC_W-1:0]   opData,
  input  logic [SRC_W-1:0]          offerSrc,
  input  logic [PRIO_W-1:0]         offerPrio,
  output dpFlags_t                  flags,
  output logic                      rdValid,
  output logic [PRIO_W+SRC_W-1:0]   rdData,
  output logic [PRIO_W-1:0]         rdIpiPrio,
  output logic                      rejValid,
  output logic [SRC_W-1:0]          rejSrc,
  output logic                      resendReq,
  output logic                      eoiValid,
  output logic [SRC_W-1:0]          eoiSrc
);

  localparam int unsigned STAT_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] thrQ, pendPrioQ, ipiQ;
  logic [SRC_W-1:0]  srcQ;
  logic [PRIO_W-1:0] newThr, ipiNew;

  assign newThr = opData[STAT_W-1 -: PRIO_W];
  assign ipiNew = opData[PRIO_W-1:0];

  always_comb begin
    flags.hasPend     = (srcQ != '0);
    flags.offerWins   = (offerPrio < thrQ) && !(flags.hasPend && (pendPrioQ <= offerPrio));
    flags.ipiWrWins   = (ipiNew < thrQ) && !(flags.hasPend && (pendPrioQ <= ipiNew));
    flags.thrDown     = (newThr < thrQ);
    flags.thrEvict    = flags.hasPend && (newThr <= pendPrioQ);
    flags.ipiUnderNew = (ipiQ < newThr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrQ      <= '0;
      srcQ      <= '0;
      pendPrioQ <= PRIO_NONE;
      ipiQ      <= PRIO_NONE;
      rdValid   <= 1'b0;
      rdData    <= '0;
      rdIpiPrio <= '0;
      rejValid  <= 1'b0;
      rejSrc    <= '0;
      resendReq <= 1'b0;
      eoiValid  <= 1'b0;
      eoiSrc    <= '0;
    end else begin
      if (stb.ipiWrite) ipiQ <= ipiNew;

      if (stb.thrFromOp)        thrQ <= newThr;
      else if (stb.thrFromPend) thrQ <= pendPrioQ;

      if (stb.pendFromOffer) begin
        srcQ      <= offerSrc;
        pendPrioQ <= offerPrio;
      end else if (stb.pendFromIpi) begin
        srcQ      <= IPI_NUM;
        pendPrioQ <= stb.ipiWrite ? ipiNew : ipiQ;
      end else if (stb.pendClear) begin
        srcQ      <= '0;
        pendPrioQ <= PRIO_NONE;
      end

      rdValid <= stb.rdCap;
      if (stb.rdCap) begin
        rdData    <= {thrQ, srcQ};
        rdIpiPrio <= ipiQ;
      end

      rejValid  <= (stb.rejOffer && (offerSrc != IPI_NUM)) ||
                   (stb.rejCur && (srcQ != IPI_NUM));
      rejSrc    <= stb.rejOffer ? offerSrc : srcQ;
      resendReq <= stb.resend;
      eoiValid  <= stb.eoiFwd;
      if (stb.eoiFwd) eoiSrc <= opData[SRC_W-1:0];
    end
  end

  AST_REJ_NEVER_IPI: assert property (@(posedge clk) disable iff (!rstN)
    rejValid |-> (rejSrc != IPI_NUM)); // R11

  AST_ACCEPT_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    stb.thrFromPend |=> (srcQ == '0) && (pendPrioQ == PRIO_NONE)); // R6

  AST_POLL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdCap && !stb.thrFromPend) |=>
      $stable(thrQ) && $stable(srcQ) && $stable(pendPrioQ) && $stable(ipiQ)); // R2

endmodule

// File: rtl/ipp_ctrl.sv
module ipp_ctrl
  import ipp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        offerValid,
  input  logic        opValid,
  input  logic [2:0]  opCode,
  input  dpFlags_t    flags,
  output ctlStrobes_t stb,
  output logic        irqOut
);

  opKind_e op;
  assign op = opKind_e'(opCode);

  always_comb begin
    stb = '0;
    if (opValid) begin
      unique case (op)
        OP_THRESH: begin
          stb.thrFromOp = 1'b1;
          if (flags.thrDown) begin
            if (flags.thrEvict) begin
              stb.pendClear = 1'b1;
              stb.rejCur    = 1'b1;
            end
          end else if (!flags.hasPend) begin
            stb.resend      = 1'b1;
            stb.pendFromIpi = flags.ipiUnderNew;
          end
        end
        OP_IPI: begin
          stb.ipiWrite = 1'b1;
          if (flags.ipiWrWins) begin
            stb.pendFromIpi = 1'b1;
            stb.rejCur      = flags.hasPend;
          end
        end
        OP_ACCEPT: begin
          stb.rdCap       = 1'b1;
          stb.thrFromPend = 1'b1;
          stb.pendClear   = 1'b1;
        end
        OP_EOI: begin
          stb.thrFromOp = 1'b1;
          stb.eoiFwd    = 1'b1;
          if (!flags.hasPend) begin
            stb.resend      = 1'b1;
            stb.pendFromIpi = flags.ipiUnderNew;
          end
        end
        OP_POLL: stb.rdCap = 1'b1;
        default: ;
      endcase
    end else if (offerValid) begin
      if (flags.offerWins) begin
        stb.pendFromOffer = 1'b1;
        stb.rejCur        = flags.hasPend;
      end else begin
        stb.rejOffer = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                  irqOut <= 1'b0;
    else if (stb.pendFromOffer || stb.pendFromIpi) irqOut <= 1'b1;
    else if (stb.pendClear)                     irqOut <= 1'b0;
  end

  AST_OFFER_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    (offerValid && !opValid && flags.offerWins) |=> irqOut); // R5

  AST_ACCEPT_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && op == OP_ACCEPT) |=> !irqOut); // R6

endmodule

// File: rtl/int_presenter.sv
module int_presenter
  import ipp_pkg::*;
#(
  parameter int unsigned SRC_W   = 24,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    offerValid,
  input  logic [SRC_W-1:0]        offerSrc,
  input  logic [PRIO_W-1:0]       offerPrio,
  input  logic                    opValid,
  input  logic [2:0]              opCode,
  input  logic [PRIO_W+SRC_W-1:0] opData,
  output logic                    rdValid,
  output logic [PRIO_W+SRC_W-1:0] rdData,
  output logic [PRIO_W-1:0]       rdIpiPrio,
  output logic                    cpuIrq,
  output logic                    rejValid,
  output logic [SRC_W-1:0]        rejSrc,
  output logic                    resendReq,
  output logic                    eoiValid,
  output logic [SRC_W-1:0]        eoiSrc
);

  ctlStrobes_t stb;
  dpFlags_t    flags;

  ipp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .offerValid(offerValid), .opValid(opValid),
    .opCode(opCode), .flags(flags), .stb(stb), .irqOut(cpuIrq)
  );

  ipp_dpath #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opData(opData),
    .offerSrc(offerSrc), .offerPrio(offerPrio), .flags(flags),
    .rdValid(rdValid), .rdData(rdData), .rdIpiPrio(rdIpiPrio),
    .rejValid(rejValid), .rejSrc(rejSrc), .resendReq(resendReq),
    .eoiValid(eoiValid), .eoiSrc(eoiSrc)
  );

  AST_IRQ_TRACKS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == flags.hasPend); // R13

  AST_REJ_RESEND_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(rejValid && resendReq)); // R9

endmodule

// File: tb/int_presenter_tb.sv
module int_presenter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        offerValid = 1'b0;
  logic [23:0] offerSrc = '0;
  logic [7:0]  offerPrio = '0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [31:0] opData = '0;
  logic        rdValid, cpuIrq, rejValid, resendReq, eoiValid;
  logic [31:0] rdData;
  logic [7:0]  rdIpiPrio;
  logic [23:0] rejSrc, eoiSrc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  int_presenter u_dut (
    .clk(clk), .rstN(rstN), .offerValid(offerValid), .offerSrc(offerSrc),
    .offerPrio(offerPrio), .opValid(opValid), .opCode(opCode), .opData(opData),
    .rdValid(rdValid), .rdData(rdData), .rdIpiPrio(rdIpiPrio), .cpuIrq(cpuIrq),
    .rejValid(rejValid), .rejSrc(rejSrc), .resendReq(resendReq),
    .eoiValid(eoiValid), .eoiSrc(eoiSrc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge capture, sample at the next falling edge
  task automatic doOp(input logic [2:0] code, input logic [31:0] data);
    opValid = 1'b1; opCode = code; opData = data;
    @(negedge clk);
    opValid = 1'b0; opCode = '0; opData = '0;
  endtask

  task automatic doOffer(input logic [23:0] src, input logic [7:0] prio);
    offerValid = 1'b1; offerSrc = src; offerPrio = prio;
    @(negedge clk);
    offerValid = 1'b0; offerSrc = '0; offerPrio = '0;
  endtask

  task automatic pollExpect(input string tag, input logic [31:0] st, input logic [7:0] ipi);
    doOp(3'd5, '0);
    chk({tag, " rdValid"}, 32'(rdValid), 32'd1);
    chk({tag, " status"}, rdData, st);
    chk({tag, " ipi"}, 32'(rdIpiPrio), 32'(ipi));
  endtask

  task automatic t_reset;
    chk("R1 irq low", 32'(cpuIrq), 32'd0);
    pollExpect("R1 R2 reset poll", 32'h0, 8'hFF);
    chk("R2 poll no reject", 32'(rejValid), 32'd0);
  endtask

  task automatic t_threshold_reject;
    doOp(3'd1, 32'h8000_0000);              // raise, empty -> resend
    chk("R9 resend on raise", 32'(resendReq), 32'd1);
    chk("R9 no reject", 32'(rejValid), 32'd0);
    chk("R9 no ipi load", 32'(cpuIrq), 32'd0);
    doOffer(24'h40, 8'h80);                 // equal to threshold
    chk("R3 reject valid", 32'(rejValid), 32'd1);
    chk("R3 reject src", 32'(rejSrc), 32'h40);
    chk("R3 irq low", 32'(cpuIrq), 32'd0);
  endtask

  task automatic t_preempt;
    doOffer(24'h41, 8'h30);
    chk("R5 latched irq", 32'(cpuIrq), 32'd1);
    chk("R5 no reject when empty", 32'(rejValid), 32'd0);
    doOffer(24'h42, 8'h30);                 // tie with pending
    chk("R4 reject tie", 32'(rejValid), 32'd1);
    chk("R4 reject src", 32'(rejSrc), 32'h42);
    doOffer(24'h43, 8'h10);
    chk("R5 old rejected", 32'(rejValid), 32'd1);
    chk("R5 old src", 32'(rejSrc), 32'h41);
    pollExpect("R5 slot", 32'h8000_0043, 8'hFF);
  endtask

  task automatic t_accept;
    doOp(3'd3, '0);
    chk("R6 returns status", rdData, 32'h8000_0043);
    chk("R6 irq low", 32'(cpuIrq), 32'd0);
    pollExpect("R6 thr from pend", 32'h1000_0000, 8'hFF);
    doOp(3'd3, '0);
    chk("R1 empty accept returns", rdData, 32'h1000_0000);
    pollExpect("R1 pend none gives FF", 32'hFF00_0000, 8'hFF);
  endtask

  task automatic t_eoi_empty;
    doOp(3'd4, 32'h8000_0043);
    chk("R10 eoi valid", 32'(eoiValid), 32'd1);
    chk("R10 eoi src", 32'(eoiSrc), 32'h43);
    chk("R10 resend", 32'(resendReq), 32'd1);
    pollExpect("R10 thr copied", 32'h8000_0000, 8'hFF);
  endtask

  task automatic t_ipi;
    doOp(3'd2, 32'h20);
    chk("R7 ipi raises", 32'(cpuIrq), 32'd1);
    chk("R7 no reject", 32'(rejValid), 32'd0);
    pollExpect("R7 ipi slot", 32'h8000_0002, 8'h20);
    doOffer(24'h50, 8'h10);
    chk("R11 ipi reject dropped", 32'(rejValid), 32'd0);
    pollExpect("R11 offer latched", 32'h8000_0050, 8'h20);
    doOp(3'd2, 32'h05);
    chk("R7 displaced reject", 32'(rejValid), 32'd1);
    chk("R7 displaced src", 32'(rejSrc), 32'h50);
    pollExpect("R7 ipi reloaded", 32'h8000_0002, 8'h05);
    doOp(3'd2, 32'h30);
    chk("R7 pending wins", 32'(rejValid), 32'd0);
    pollExpect("R7 unchanged slot", 32'h8000_0002, 8'h30);
  endtask

  task automatic t_evict;
    doOp(3'd3, '0);
    chk("R6 accept ipi", rdData, 32'h8000_0002);
    doOp(3'd4, 32'h8000_0002);
    chk("R10 resend", 32'(resendReq), 32'd1);
    chk("R10 ipi reload irq", 32'(cpuIrq), 32'd1);
    pollExpect("R10 ipi from stored", 32'h8000_0002, 8'h30);
    doOffer(24'h60, 8'h20);
    chk("R11 dropped", 32'(rejValid), 32'd0);
    doOp(3'd1, 32'h2000_0000);
    chk("R8 evict reject", 32'(rejValid), 32'd1);
    chk("R8 evict src", 32'(rejSrc), 32'h60);
    chk("R8 irq low", 32'(cpuIrq), 32'd0);
    pollExpect("R8 slot cleared", 32'h2000_0000, 8'h30);
  endtask

  task automatic t_raise_ipi;
    doOp(3'd2, 32'h10);                     // 0x10 < 0x20, empty -> IPI
    doOp(3'd3, '0);
    chk("R6 accept", rdData, 32'h2000_0002);
    doOp(3'd1, 32'h4000_0000);
    chk("R9 resend", 32'(resendReq), 32'd1);
    chk("R9 ipi check irq", 32'(cpuIrq), 32'd1);
    pollExpect("R9 ipi loaded", 32'h4000_0002, 8'h10);
  endtask

  task automatic t_conflict;
    offerValid = 1'b1; offerSrc = 24'h70; offerPrio = 8'h00;
    doOp(3'd5, '0);
    offerValid = 1'b0; offerSrc = '0; offerPrio = '0;
    chk("R12 no reject", 32'(rejValid), 32'd0);
    chk("R12 poll status", rdData, 32'h4000_0002);
    pollExpect("R12 offer discarded", 32'h4000_0002, 8'h10);
    doOp(3'd4, 32'h4000_0077);
    chk("R10 eoi src busy", 32'(eoiSrc), 32'h77);
    chk("R10 no resend when busy", 32'(resendReq), 32'd0);
    chk("R13 irq held", 32'(cpuIrq), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold_reject();
    t_preempt();
    t_accept();
    t_eoi_empty();
    t_ipi();
    t_evict();
    t_raise_ipi();
    t_conflict();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule